// File: doc/BRIEF.md
# Hysteretic DMA Request Controller for a Byte FIFO

This block raises and drops the DMA request line for a host-to-device transfer that fills a byte FIFO. The request goes up when a data-transfer execution phase starts. It stays up while the host writes bytes, and it falls once the FIFO reports full. It rises again when the FIFO occupancy falls to a programmable threshold. This hysteresis lets the host move bursts of bytes rather than trickling them in one at a time.

The host answers a request by pulling its acknowledge low and then strobing a write with data. Both strobes are asynchronous to the block. They are synchronized into the clock domain, and their falling edges are detected there. Each accepted strobe produces one FIFO write pulse with the captured byte.

Terminal count ends the phase, but only when it is seen together with an active acknowledge. The request drops on the acknowledge falling edge. If the acknowledge is already low, so that no edge appears, the request drops on the write-strobe edge of the final byte instead. The FIFO itself and its disk-side reader sit outside the block. They report their state through the full and occupancy inputs.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_ni is low, req_o, fifo_we_o, last_o and overrun_o are all 0.
- R2: A cycle with exec_start_i high sets req_o to 1 on the next cycle and clears overrun_o.
- R3: A falling edge of wr_ni while dack_ni is low, during an active phase and with the FIFO not full, gives exactly one fifo_we_o pulse carrying wdata_i. The pulse comes 3 cycles after the strobe falls (2 synchronizer stages plus 1 output register). Strobes outside an active phase are ignored.
- R4: Once asserted, req_o stays 1 while fifo_full_i is 0. req_o goes to 0 on the cycle after fifo_full_i is seen at 1.
- R5: While the phase is running, req_o is 0 and fifo_full_i is 0, req_o returns to 1 on the cycle after fifo_cnt_i <= thresh_i. thresh_i is 4 bits (0..15) and fifo_cnt_i is 5 bits (0..16).
- R6: A write strobe accepted while fifo_full_i is 1 produces no fifo_we_o pulse. It sets overrun_o, which stays 1 until the next exec_start_i.
- R7: tc_i is ignored while dack_ni is high. req_o does not change because of it.
- R8: A falling edge of dack_ni with tc_i high drops req_o 3 cycles after the edge, before any byte is written. The request does not re-arm for the rest of the phase.
- R9: If dack_ni is already low, so there is no edge, a falling edge of wr_ni with tc_i high drops req_o and ends the phase.
- R10: last_o is 1 together with the fifo_we_o pulse of the byte written with tc_i high, and 0 with every other pulse.
- R11: After the phase has ended by terminal count, draining the FIFO to any level does not raise req_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_start_i | input | 1 | One-cycle pulse: a data-transfer execution phase begins |
| dack_ni | input | 1 | DMA acknowledge from the host, active low, asynchronous |
| wr_ni | input | 1 | Host write strobe, active low, asynchronous |
| tc_i | input | 1 | Terminal count from the host |
| wdata_i | input | 8 | Byte driven by the host during the strobe |
| thresh_i | input | 4 | Occupancy level at which the request re-arms |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_cnt_i | input | 5 | FIFO occupancy in bytes |
| req_o | output | 1 | DMA request |
| fifo_we_o | output | 1 | FIFO write enable, one cycle per byte |
| fifo_wdata_o | output | 8 | Byte to write into the FIFO |
| last_o | output | 1 | Marks the final byte of the transfer |
| overrun_o | output | 1 | Sticky flag: a write was dropped because the FIFO was full |

## Verification
Each result has a fixed latency. A write pulse comes three cycles after the strobe falls. A request drop caused by acknowledge with terminal count comes three cycles after the acknowledge falls. A drop or re-arm caused by FIFO status comes one cycle after the status changes. The bench FIFO model adds one more cycle, because it updates its count on the edge after a write pulse.

The bench drives every input on a falling clock edge and waits whole cycles past each of these latencies before sampling on a falling edge. Randomized rounds fill the FIFO and then drain it to a random level against a random threshold. The bench predicts the re-arm from the level and the threshold alone.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int unsigned IDX_DACK = 0;
  localparam int unsigned IDX_WR   = 1;
  localparam int unsigned N_STROBE = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/dmr_sync_edge.sv
module dmr_sync_edge #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '1;
        prev_q <= 1'b1;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], d_i[g]};
        prev_q <= sh_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sh_q[STAGES-1];
    assign fall_o[g] = prev_q & ~sh_q[STAGES-1];
  end
endmodule

// File: rtl/dmr_wr_path.sv
module dmr_wr_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_start_i,
  input  logic          active_i,
  input  logic          wr_fall_i,
  input  logic          wr_lvl_i,
  input  logic          dack_lvl_i,
  input  logic          tc_i,
  input  logic          fifo_full_i,
  input  logic [DW-1:0] wdata_i,
  output logic          last_hit_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          last_o,
  output logic          overrun_o
);
  logic wr_hit;
  assign wr_hit     = wr_fall_i & ~dack_lvl_i & active_i;
  assign last_hit_o = wr_hit & tc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o      <= 1'b0;
      last_o    <= 1'b0;
      wdata_o   <= '0;
      overrun_o <= 1'b0;
    end else begin
      we_o   <= wr_hit & ~fifo_full_i;
      last_o <= wr_hit & ~fifo_full_i & tc_i;
      // track host data while strobe is low; value at the edge cycle goes out
      if (!wr_lvl_i) wdata_o <= wdata_i;
      if (exec_start_i)              overrun_o <= 1'b0;
      else if (wr_hit & fifo_full_i) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dmr_req_fsm.sv
module dmr_req_fsm
  import dmr_pkg::*;
#(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_start_i,
  input  logic             dack_fall_i,
  input  logic             tc_i,
  input  logic             last_hit_i,
  input  logic             fifo_full_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             req_o,
  output logic             active_o
);
  phase_e ph_q;
  logic   rearm;

  assign active_o = (ph_q != PH_IDLE);
  assign rearm    = ~fifo_full_i & (fifo_cnt_i <= CNT_W'(thresh_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      req_o <= 1'b0;
    end else if (exec_start_i) begin
      ph_q  <= PH_RUN;
      req_o <= 1'b1;
    end else if (last_hit_i) begin
      ph_q  <= PH_IDLE;
      req_o <= 1'b0;
    end else if (ph_q == PH_RUN) begin
      if (dack_fall_i & tc_i) begin
        // qualified TC: drop now, still accept the final byte
        ph_q  <= PH_TAIL;
        req_o <= 1'b0;
      end else if (req_o & fifo_full_i) begin
        req_o <= 1'b0;
      end else if (!req_o & rearm) begin
        req_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dmr_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(DEPTH + 1),
  localparam int unsigned THR_W      = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_start_i,
  input  logic             dack_ni,
  input  logic             wr_ni,
  input  logic             tc_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [THR_W-1:0] thresh_i,
  input  logic             fifo_full_i,
  input  logic [CNT_W-1:0] fifo_cnt_i,
  output logic             req_o,
  output logic             fifo_we_o,
  output logic [DW-1:0]    fifo_wdata_o,
  output logic             last_o,
  output logic             overrun_o
);
  logic [N_STROBE-1:0] s_lvl, s_fall, s_raw;
  logic active, last_hit;

  assign s_raw[IDX_DACK] = dack_ni;
  assign s_raw[IDX_WR]   = wr_ni;

  dmr_sync_edge #(.N(N_STROBE), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(s_raw), .lvl_o(s_lvl), .fall_o(s_fall)
  );

  dmr_wr_path #(.DW(DW)) u_wr (
    .clk_i, .rst_ni, .exec_start_i,
    .active_i   (active),
    .wr_fall_i  (s_fall[IDX_WR]),
    .wr_lvl_i   (s_lvl[IDX_WR]),
    .dack_lvl_i (s_lvl[IDX_DACK]),
    .tc_i, .fifo_full_i, .wdata_i,
    .last_hit_o (last_hit),
    .we_o       (fifo_we_o),
    .wdata_o    (fifo_wdata_o),
    .last_o, .overrun_o
  );

  dmr_req_fsm #(.CNT_W(CNT_W), .THR_W(THR_W)) u_fsm (
    .clk_i, .rst_ni, .exec_start_i,
    .dack_fall_i (s_fall[IDX_DACK]),
    .tc_i,
    .last_hit_i  (last_hit),
    .fifo_full_i, .fifo_cnt_i, .thresh_i,
    .req_o,
    .active_o    (active)
  );
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic exec_start_i,
  input logic fifo_full_i,
  input logic req_o,
  input logic fifo_we_o,
  input logic last_o,
  input logic overrun_o
);
  a_r2_start_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_i |=> req_o);
  a_r2_start_clears_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_i |=> !overrun_o);
  a_r4_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && fifo_full_i && !exec_start_i) |=> !req_o);
  a_r5_no_rearm_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && fifo_full_i && !exec_start_i) |=> !req_o);
  a_r6_no_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> !$past(fifo_full_i));
  a_r10_last_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> fifo_we_o);
endmodule

bind dma_req_ctrl dma_req_ctrl_chk u_chk (.*);

// File: tb/sim_dma_req_ctrl.sv
module sim_dma_req_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       exec_start = 0, dack_n = 1, wr_n = 1, tc = 0, rd = 0, flush = 0;
  logic [7:0] wdata = 0;
  logic [3:0] thresh = 0;
  logic       req, we, last, ovr;
  logic [7:0] wdo;
  int unsigned occ = 0;
  int checks = 0, fails = 0, we_cnt = 0;
  logic [7:0] last_data = 0;
  logic       last_flag = 0;
  bit done = 0;

  dma_req_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .exec_start_i(exec_start), .dack_ni(dack_n),
    .wr_ni(wr_n), .tc_i(tc), .wdata_i(wdata), .thresh_i(thresh),
    .fifo_full_i(occ == 16), .fifo_cnt_i(5'(occ)),
    .req_o(req), .fifo_we_o(we), .fifo_wdata_o(wdo), .last_o(last), .overrun_o(ovr)
  );

  // FIFO model on the consumer side
  always @(posedge clk) begin
    if (flush) occ <= 0;
    else occ <= occ + (we ? 1 : 0) - ((rd && occ != 0) ? 1 : 0);
  end

  always @(negedge clk) if (we) begin
    we_cnt    <= we_cnt + 1;
    last_data <= wdo;
    last_flag <= last;
  end

  function automatic bit exp_rearm(int lvl, int thr);
    return lvl <= thr;
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_exec();
    exec_start = 1; flush = 1;
    cyc(1);
    exec_start = 0; flush = 0;
  endtask

  task automatic host_write(logic [7:0] d, bit t, bit keep_dack);
    dack_n = 0;
    cyc(1);
    wdata = d; tc = t; wr_n = 0;
    cyc(4);
    wr_n = 1;
    if (!keep_dack) dack_n = 1;
    cyc(2);
    tc = 0;
  endtask

  task automatic drain(int n);
    if (n > 0) begin
      rd = 1; cyc(n); rd = 0;
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    cyc(3);
    chk("R1 req", req, 0); chk("R1 we", we, 0);
    chk("R1 last", last, 0); chk("R1 ovr", ovr, 0);
    rst_n = 1;
    cyc(2);

    thresh = 5;
    start_exec();
    chk("R2 req", req, 1); chk("R2 ovr", ovr, 0);

    host_write(8'hA5, 0, 0);
    chk("R3 we count", we_cnt, 1); chk("R3 data", last_data, 8'hA5);
    chk("R10 not last", last_flag, 0); chk("R4 req held", req, 1);
    for (int i = 0; i < 14; i++) host_write(8'(i), 0, 0);
    chk("R4 req before full", req, 1);
    host_write(8'hF0, 0, 0);
    cyc(2);
    chk("R4 occ", occ, 16); chk("R4 req dropped", req, 0);

    base = we_cnt;
    host_write(8'h99, 0, 0);
    chk("R6 dropped", we_cnt, base); chk("R6 overrun", ovr, 1);

    drain(10); cyc(3);
    chk("R5 above thr", req, 0);
    drain(1); cyc(3);
    chk("R5 at thr", req, 1);
    chk("R6 sticky", ovr, 1);

    tc = 1; cyc(6);
    chk("R7 tc unqualified", req, 1);
    tc = 0;

    start_exec();
    chk("R6 cleared", ovr, 0); chk("R2 req again", req, 1);

    // R8: acknowledge edge with TC drops request before data
    base = we_cnt;
    dack_n = 0; tc = 1; cyc(4);
    chk("R8 req dropped", req, 0); chk("R8 no write yet", we_cnt, base);
    wdata = 8'h3C; wr_n = 0; cyc(4);
    wr_n = 1; dack_n = 1; tc = 0; cyc(2);
    chk("R8 byte written", we_cnt, base + 1);
    chk("R10 last flag", last_flag, 1); chk("R10 last data", last_data, 8'h3C);
    drain(4); cyc(4);
    chk("R11 no rearm", req, 0);
    host_write(8'h77, 0, 0);
    chk("R3 ignored idle", we_cnt, base + 1);

    // R9: acknowledge held low, strobe edge carries TC
    start_exec();
    host_write(8'h11, 0, 1);
    tc = 1; cyc(3);
    chk("R9 no edge yet", req, 1);
    wdata = 8'h22; wr_n = 0; cyc(4);
    chk("R9 req dropped", req, 0);
    wr_n = 1; dack_n = 1; tc = 0; cyc(2);
    chk("R10 last R9", last_flag, 1); chk("R9 data", last_data, 8'h22);

    for (int it = 0; it < 20; it++) begin
      int thr, lvl;
      logic [7:0] d;
      thr = (it == 0) ? 15 : (it == 1) ? 0 : int'($urandom % 16);
      lvl = (it == 0) ? 15 : (it == 1) ? 0 : int'($urandom % 16);
      thresh = 4'(thr);
      start_exec();
      for (int k = 0; k < 16; k++) begin
        d = 8'($urandom);
        base = we_cnt;
        host_write(d, 0, 0);
        chk("R3 rnd count", we_cnt, base + 1);
        chk("R3 rnd data", last_data, d);
      end
      cyc(2);
      chk("R4 rnd full drop", req, 0);
      drain(16 - lvl); cyc(3);
      chk("R5 rnd rearm", req, int'(exp_rearm(lvl, thr)));
    end
    finish_sim();
  end
endmodule